// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block collects interrupt causes from two serial channels and turns them into one prioritized request for the CPU. Each channel reports three causes as single-cycle strobes: a receive error, a receive buffer filling, and a transmit buffer emptying. A receive-full strobe comes when a received byte moves from the shift register into the receive data register. A transmit-empty strobe comes when a byte leaves the transmit data register for the shift register. Every strobe latches into a cause flag. Each flag is gated by an enable bit. Each channel carries its own 3-bit priority level.

Software reaches five registers through a small synchronous register bus. These hold the enable bits, the cause flags, the per-channel levels, a per-channel 2-bit interface mode code, and a one-bit flag write method. The mode code is only stored and read back. In the clear-only method, ones written to the flags clear them. In the read/write method, the written value replaces the flags. The request output gives the winning channel number and its level.

Top module: `ser_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 (enables, flags, levels, mode codes and the write method), and `irq_req_o` is low.
- R2: Enable and flag registers share one layout: for channel c, bit 3c is receive error, bit 3c+1 is receive full and bit 3c+2 is transmit empty. The enable register is at address 0 and reads back bits 5:0, with bits 7:6 reading 0.
- R3: A cause strobe sampled high at a clock edge sets its flag (address 1) from that edge on, even when the matching enable bit is 0.
- R4: When the method bit is 0 (clear-only), a flag write clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R5: When the method bit is 1 (read/write), a flag write loads bits 5:0 of the data into the flags.
- R6: A cause strobe and a flag write that would clear the same flag in the same cycle leave that flag set, in both methods.
- R7: A channel is pending when at least one of its flags and the matching enable bit are both 1 and its level is nonzero. `irq_req_o` is high exactly when some channel is pending.
- R8: Among pending channels, the one with the higher level wins, and channel 0 wins a tie. `irq_lvl_o` and `irq_ch_o` give the winner, and both read 0 when there is no request.
- R9: Address 2 holds the levels: channel 0 in bits 2:0 and channel 1 in bits 6:4. Address 3 holds the mode codes: channel 0 in bits 1:0 and channel 1 in bits 3:2 (00 normal, 10 IrDA, 01 and 11 reserved, all stored as written). Address 4 bit 0 holds the method. All other bits read 0.
- R10: A write is taken at the clock edge where `bus_we_i` is high and shows on reads and outputs right after that edge. Reads are combinational, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| err_evt_i | input | 2 | Receive error strobe, one bit per channel |
| rxf_evt_i | input | 2 | Receive buffer full strobe, one bit per channel |
| txe_evt_i | input | 2 | Transmit buffer empty strobe, one bit per channel |
| irq_req_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Level of the winning channel |
| irq_ch_o | output | 1 | Winning channel number |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear landing on the same flag in the same cycle. The bench raises a cause strobe in exactly the cycle in which it writes the flag register. It does this for every flag bit, once with an all-ones write in the clear-only method and once with an all-zeros write in the read/write method. The other checks are full sweeps: all 64 by 64 flag and write-data pairs in the clear-only method, and all 64 level pairs across four enable patterns, each scored against arithmetic in the bench.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int CAUSES = 3;

  typedef enum logic [1:0] {
    CAUSE_ERR = 2'd0,
    CAUSE_RXF = 2'd1,
    CAUSE_TXE = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_FLAG   = 3'd1,
    REG_LEVEL  = 3'd2,
    REG_MODE   = 3'd3,
    REG_METHOD = 3'd4
  } reg_addr_e;

  typedef enum logic {
    WM_CLEAR_ONLY = 1'b0,
    WM_READ_WRITE = 1'b1
  } wr_method_e;
endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg
  import ser_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LVL_W  = 3,
  parameter int MODE_W = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int FLAG_W   = NUM_CH * CAUSES,
  localparam int LVL_SLOT = LVL_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [FLAG_W-1:0]              en_o,
  output logic [NUM_CH-1:0][LVL_W-1:0]   lvl_o,
  output logic [NUM_CH-1:0][MODE_W-1:0]  mode_o,
  output wr_method_e                     method_o
);
  logic wr_en, wr_lvl, wr_mode, wr_meth;

  assign wr_en   = we_i && (addr_i == ADDR_W'(REG_ENABLE));
  assign wr_lvl  = we_i && (addr_i == ADDR_W'(REG_LEVEL));
  assign wr_mode = we_i && (addr_i == ADDR_W'(REG_MODE));
  assign wr_meth = we_i && (addr_i == ADDR_W'(REG_METHOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= '0;
      method_o <= WM_CLEAR_ONLY;
    end else begin
      if (wr_en)   en_o     <= wdata_i[FLAG_W-1:0];
      if (wr_meth) method_o <= wr_method_e'(wdata_i[0]);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_o[c]  <= '0;
        mode_o[c] <= '0;
      end else begin
        if (wr_lvl)  lvl_o[c]  <= wdata_i[c*LVL_SLOT +: LVL_W];
        if (wr_mode) mode_o[c] <= wdata_i[c*MODE_W +: MODE_W];
      end
    end
  end
endmodule

// File: rtl/sirq_flags.sv
module sirq_flags
  import ser_irq_pkg::*;
#(
  parameter int FLAG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  wr_method_e        method_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] sw_next;

  always_comb begin
    sw_next = flags_o;
    if (wr_i) begin
      if (method_i == WM_READ_WRITE) sw_next = wdata_i;
      else                           sw_next = flags_o & ~wdata_i;
    end
  end

  // hardware set overrides any software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= sw_next | set_i;
  end
endmodule

// File: rtl/sirq_arb.sv
module sirq_arb
  import ser_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LVL_W  = 3,
  localparam int FLAG_W = NUM_CH * CAUSES,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [FLAG_W-1:0]            flags_i,
  input  logic [FLAG_W-1:0]            en_i,
  input  logic [NUM_CH-1:0][LVL_W-1:0] lvl_i,
  output logic                         req_o,
  output logic [LVL_W-1:0]             lvl_o,
  output logic [CH_W-1:0]              ch_o
);
  logic [NUM_CH-1:0] pend;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pend[c] = (|(flags_i[c*CAUSES +: CAUSES] & en_i[c*CAUSES +: CAUSES]))
                     && (lvl_i[c] != '0);
  end

  // strict compare keeps the lower channel on equal levels
  always_comb begin
    req_o = 1'b0;
    lvl_o = '0;
    ch_o  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pend[c] && (!req_o || (lvl_i[c] > lvl_o))) begin
        req_o = 1'b1;
        lvl_o = lvl_i[c];
        ch_o  = CH_W'(c);
      end
    end
  end
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl
  import ser_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LVL_W  = 3,
  parameter int MODE_W = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int FLAG_W   = NUM_CH * CAUSES,
  localparam int LVL_SLOT = LVL_W + 1,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [NUM_CH-1:0] rxf_evt_i,
  input  logic [NUM_CH-1:0] txe_evt_i,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [CH_W-1:0]   irq_ch_o
);
  logic [FLAG_W-1:0]             en_q, flags_q, evt_set;
  logic [NUM_CH-1:0][LVL_W-1:0]  lvl_q;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
  wr_method_e                    method_q;
  logic                          flag_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_evt
    assign evt_set[c*CAUSES + int'(CAUSE_ERR)] = err_evt_i[c];
    assign evt_set[c*CAUSES + int'(CAUSE_RXF)] = rxf_evt_i[c];
    assign evt_set[c*CAUSES + int'(CAUSE_TXE)] = txe_evt_i[c];
  end

  assign flag_wr = bus_we_i && (bus_addr_i == ADDR_W'(REG_FLAG));

  sirq_cfg #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .MODE_W(MODE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .en_o     (en_q),
    .lvl_o    (lvl_q),
    .mode_o   (mode_q),
    .method_o (method_q)
  );

  sirq_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .wr_i     (flag_wr),
    .wdata_i  (bus_wdata_i[FLAG_W-1:0]),
    .method_i (method_q),
    .flags_o  (flags_q)
  );

  sirq_arb #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_arb (
    .flags_i (flags_q),
    .en_i    (en_q),
    .lvl_i   (lvl_q),
    .req_o   (irq_req_o),
    .lvl_o   (irq_lvl_o),
    .ch_o    (irq_ch_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(REG_ENABLE): bus_rdata_o[FLAG_W-1:0] = en_q;
      ADDR_W'(REG_FLAG):   bus_rdata_o[FLAG_W-1:0] = flags_q;
      ADDR_W'(REG_LEVEL):
        for (int c = 0; c < NUM_CH; c++) bus_rdata_o[c*LVL_SLOT +: LVL_W] = lvl_q[c];
      ADDR_W'(REG_MODE):
        for (int c = 0; c < NUM_CH; c++) bus_rdata_o[c*MODE_W +: MODE_W] = mode_q[c];
      ADDR_W'(REG_METHOD): bus_rdata_o[0] = method_q;
      default:             bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ser_irq_chk.sv
module ser_irq_chk
  import ser_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int FLAG_W = NUM_CH * CAUSES,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wdata_i,
  input logic [FLAG_W-1:0]            evt_i,
  input logic [FLAG_W-1:0]            flags_i,
  input logic [FLAG_W-1:0]            en_i,
  input logic [NUM_CH-1:0][LVL_W-1:0] lvl_i,
  input logic                         method_i,
  input logic                         req_i,
  input logic [LVL_W-1:0]             req_lvl_i,
  input logic [CH_W-1:0]              req_ch_i
);
  logic clr_wr;
  assign clr_wr = we_i && (addr_i == ADDR_W'(REG_FLAG)) && (method_i == 1'b0);

  a_r3_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_i & $past(evt_i)) == $past(evt_i)));

  a_r4_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((flags_i & $past(flags_i) & ~$past(wdata_i[FLAG_W-1:0]))
               == ($past(flags_i) & ~$past(wdata_i[FLAG_W-1:0]))));

  a_r7_req_needs_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (|(flags_i & en_i)));

  a_r8_level_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (req_lvl_i != '0));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (req_lvl_i == '0 && req_ch_i == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic pend;
    assign pend = (|(flags_i[c*CAUSES +: CAUSES] & en_i[c*CAUSES +: CAUSES])) && (lvl_i[c] != '0);

    a_r7_pending_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend |-> req_i);

    a_r8_winner_not_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && pend) |-> (req_lvl_i >= lvl_i[c]));

    a_r8_tie_low_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && pend && req_lvl_i == lvl_i[c]) |-> (int'(req_ch_i) <= c));
  end
endmodule

bind ser_irq_ctrl ser_irq_chk #(
  .NUM_CH(NUM_CH), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (bus_we_i),
  .addr_i    (bus_addr_i),
  .wdata_i   (bus_wdata_i),
  .evt_i     (evt_set),
  .flags_i   (flags_q),
  .en_i      (en_q),
  .lvl_i     (lvl_q),
  .method_i  (method_q),
  .req_i     (irq_req_o),
  .req_lvl_i (irq_lvl_o),
  .req_ch_i  (irq_ch_o)
);

// File: tb/sim_ser_irq_ctrl.sv
module sim_ser_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] err = '0, rxf = '0, txe = '0;
  logic       req;
  logic [2:0] lvl;
  logic       ch;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .err_evt_i(err), .rxf_evt_i(rxf), .txe_evt_i(txe),
    .irq_req_o(req), .irq_lvl_o(lvl), .irq_ch_o(ch)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // strobe one cause bit; optionally write the flag register in the same cycle
  task automatic strobe(input int b, input bit do_wr, input logic [7:0] d);
    @(negedge clk);
    case (b % 3)
      0: err[b/3] = 1'b1;
      1: rxf[b/3] = 1'b1;
      default: txe[b/3] = 1'b1;
    endcase
    if (do_wr) begin we = 1'b1; addr = 3'd1; wdata = d; end
    @(negedge clk);
    err = '0; rxf = '0; txe = '0; we = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [5:0] en_v;
    logic       ereq, ech;
    logic [2:0] elvl;
    bit         p0, p1;

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reset reg", d, 0);
    end
    chk("R1 reset req", req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after release", req, 0);

    // R2 enable readback, R10 write timing
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      rd(3'd0, d);
      chk("R2 enable readback", d, v & 8'h3F);
    end

    // R9 level, mode, method readback
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      rd(3'd2, d);
      chk("R9 level reg", d, v & 8'h77);
    end
    for (int v = 0; v < 256; v += 3) begin
      wr(3'd3, 8'(v));
      rd(3'd3, d);
      chk("R9 mode reg", d, v & 8'h0F);
    end
    wr(3'd4, 8'hFF);
    rd(3'd4, d);
    chk("R9 method reg", d, 1);

    // R10 unmapped addresses read zero
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d);
      chk("R10 unmapped read", d, 0);
    end

    // R5 read/write method loads flags
    wr(3'd0, 8'h00);
    for (int v = 0; v < 64; v++) begin
      wr(3'd1, 8'(v) | 8'hC0);
      rd(3'd1, d);
      chk("R5 rw load", d, v);
    end

    // R4 clear-only sweep over all init/write pairs
    for (int f = 0; f < 64; f++) begin
      for (int w = 0; w < 64; w++) begin
        wr(3'd4, 8'h01);
        wr(3'd1, 8'(f));
        wr(3'd4, 8'h00);
        wr(3'd1, 8'(w));
        rd(3'd1, d);
        chk("R4 clear-only", d, f & ~w & 8'h3F);
      end
    end

    // R3 strobes set flags with enables off; R2 bit position
    for (int b = 0; b < 6; b++) begin
      wr(3'd4, 8'h01);
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h00);
      strobe(b, 1'b0, 8'h00);
      rd(3'd1, d);
      chk("R3 strobe sets flag", d, 1 << b);
      chk("R7 disabled no req", req, 0);
    end

    // R6 set beats same-cycle clear
    for (int b = 0; b < 6; b++) begin
      wr(3'd4, 8'h01);
      wr(3'd1, 8'h3F);
      wr(3'd4, 8'h00);
      strobe(b, 1'b1, 8'hFF);
      rd(3'd1, d);
      chk("R6 clear-only collision", d, 1 << b);
      wr(3'd4, 8'h01);
      wr(3'd1, 8'h3F);
      strobe(b, 1'b1, 8'h00);
      rd(3'd1, d);
      chk("R6 rw collision", d, 1 << b);
    end

    // R7 enabled but no flags
    wr(3'd4, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h3F);
    wr(3'd2, 8'h77);
    @(negedge clk);
    chk("R7 no flag no req", req, 0);

    // R7 R8 arbitration sweep
    wr(3'd1, 8'h3F);
    for (int s = 0; s < 4; s++) begin
      en_v = {(s[1] ? 3'b100 : 3'b000), (s[0] ? 3'b010 : 3'b000)};
      wr(3'd0, 8'(en_v));
      for (int l0 = 0; l0 < 8; l0++) begin
        for (int l1 = 0; l1 < 8; l1++) begin
          wr(3'd2, 8'((l1 << 4) | l0));
          p0 = s[0] && l0 != 0;
          p1 = s[1] && l1 != 0;
          ereq = p0 || p1;
          ech  = p1 && (!p0 || l1 > l0);
          elvl = !ereq ? 3'd0 : (ech ? 3'(l1) : 3'(l0));
          chk("R7 req", req, ereq);
          chk("R8 level", lvl, elvl);
          chk("R8 channel", ch, ech);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule